// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block deserialises stereo PCM audio carried on a bit clock, a word clock that separates the left and right channel slots, and a single data line. It runs entirely on the bit clock: the word clock and the data line are both sampled on the rising edge of that clock. The block returns each left/right pair as two parallel words together with a one-cycle strobe.

A 3-bit format code selects one of eight combinations of framing and word width. The framing is right-justified, left-justified or I2S, and the width is 16, 20 or 24 bits. A polarity input selects which word-clock level marks the left channel. Captured words are sign-extended to 24 bits. All formats share one shift register and one slot-position counter. The format code only selects which bits are taken and in which cycle.

A slot that began before the receiver first saw a word-clock edge is treated as partial and discarded. A right word that arrives without a left word of the same frame ahead of it is dropped. Because of these two rules, the first strobe after reset always carries a complete, correctly ordered pair.

Top module: `aud_frame_rx`

## Requirements
- R1: The data line and the word clock are sampled on the rising edge of the bit clock, and every word arrives MSB first.
- R2: The format code decodes as: 000 = 16-bit right-justified, 001 = 20-bit right-justified, 010 = 24-bit right-justified, 011 = 24-bit left-justified, 100 = 16-bit I2S, 101 = 24-bit I2S, 110 = 20-bit I2S, 111 = 20-bit left-justified.
- R3: In right-justified framing, the word is the last N bits sampled before the word-clock transition that ends the slot. Any earlier bits in the slot are ignored, and this includes a slot of exactly N bits.
- R4: In left-justified framing, the word is the first N bits sampled from the cycle of the word-clock transition onward. Any later bits in the slot are ignored.
- R5: In I2S framing, the word starts one bit-clock cycle after the word-clock transition and spans N bits. The bit sampled at the transition and any bits after the word are ignored.
- R6: With the polarity input at 0, word clock high marks the left slot. With it at 1, word clock low marks the left slot. Within a frame, the left word precedes the right word.
- R7: Each output word equals the captured N bits sign-extended to 24 bits, using bit N-1 as the sign.
- R8: The pair strobe is high for exactly one cycle, in the cycle after the right word of a frame is captured, provided the left word of that frame was captured before it. Both output words update only at the strobe and hold their values between strobes.
- R9: Reset drives both output words to zero and holds the strobe low. A slot that started before the first word-clock edge after reset produces no word.
- R10: A right word captured with no preceding left word since the last strobe or reset produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk | input | 1 | Word clock marking left and right channel slots |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt_code | input | 3 | Framing and width select (see R2) |
| lr_pol | input | 1 | Word-clock polarity for the left channel (see R6) |
| left_word | output | 24 | Last left sample, sign-extended |
| right_word | output | 24 | Last right sample, sign-extended |
| pair_valid | output | 1 | One-cycle strobe when a new left/right pair is presented |

## Verification
The assertions assume that the format code and the polarity input stay constant while the receiver is out of reset. They also assume that every complete channel slot is at least as long as the selected word, plus one bit in I2S framing, and that each slot spans at least two bit-clock cycles. The stimulus meets these assumptions by applying reset before every change of format or polarity, and by always using slot lengths of 24, 25 or 32 bits. Short partial slots occur only before the first word-clock edge, where the receiver is required to ignore them.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic [1:0] {
      FRM_RJ  = 2'd0,
      FRM_LJ  = 2'd1,
      FRM_I2S = 2'd2
   } frame_e;

   typedef enum logic [1:0] {
      WSEL_SHORT = 2'd0,
      WSEL_MID   = 2'd1,
      WSEL_LONG  = 2'd2
   } wsel_e;

   typedef struct packed {
      frame_e frame;
      wsel_e  wsel;
   } fmt_t;

   localparam int NUM_WSEL = 3;

   function automatic fmt_t decode_fmt(input logic [2:0] code);
      fmt_t f;
      case (code)
         3'b000:  f = '{frame: FRM_RJ,  wsel: WSEL_SHORT};
         3'b001:  f = '{frame: FRM_RJ,  wsel: WSEL_MID};
         3'b010:  f = '{frame: FRM_RJ,  wsel: WSEL_LONG};
         3'b011:  f = '{frame: FRM_LJ,  wsel: WSEL_LONG};
         3'b100:  f = '{frame: FRM_I2S, wsel: WSEL_SHORT};
         3'b101:  f = '{frame: FRM_I2S, wsel: WSEL_LONG};
         3'b110:  f = '{frame: FRM_I2S, wsel: WSEL_MID};
         default: f = '{frame: FRM_LJ,  wsel: WSEL_MID};
      endcase
      return f;
   endfunction

endpackage

// File: rtl/aud_rx_slot.sv
module aud_rx_slot #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wclk,
   input  logic             lr_pol,
   output logic             slot_edge,
   output logic [CNT_W-1:0] bit_idx,
   output logic             cur_left,
   output logic             prev_left,
   output logic             synced
);
   localparam logic [CNT_W-1:0] IDX_MAX = '1;

   logic             primed_q;
   logic             wclk_q;
   logic             synced_q;
   logic [CNT_W-1:0] idx_q;

   assign slot_edge = primed_q && (wclk != wclk_q);
   assign cur_left  = wclk ^ lr_pol;
   assign prev_left = wclk_q ^ lr_pol;
   assign synced    = synced_q;

   always_comb begin
      if (slot_edge)
         bit_idx = '0;
      else if (idx_q == IDX_MAX)
         bit_idx = idx_q;
      else
         bit_idx = idx_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         wclk_q   <= 1'b0;
         synced_q <= 1'b0;
         idx_q    <= IDX_MAX;
      end else begin
         primed_q <= 1'b1;
         wclk_q   <= wclk;
         idx_q    <= bit_idx;
         if (slot_edge)
            synced_q <= 1'b1;
      end
   end
endmodule

// File: rtl/aud_rx_shift.sv
module aud_rx_shift #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sdata,
   output logic [W-1:0] sr_q,
   output logic [W-1:0] word_now
);
   assign word_now = {sr_q[W-2:0], sdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr_q <= '0;
      else
         sr_q <= word_now;
   end
endmodule

// File: rtl/aud_rx_capture.sv
module aud_rx_capture
   import aud_rx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int W_SHORT  = 16,
   parameter int W_MID    = 20,
   parameter int CNT_W    = 5
) (
   input  fmt_t                fmt,
   input  logic                slot_edge,
   input  logic [CNT_W-1:0]    bit_idx,
   input  logic                synced,
   input  logic                cur_left,
   input  logic                prev_left,
   input  logic [SAMPLE_W-1:0] sr_q,
   input  logic [SAMPLE_W-1:0] word_now,
   output logic                cap_stb,
   output logic                cap_left,
   output logic [SAMPLE_W-1:0] cap_word
);
   logic [SAMPLE_W-1:0] src;
   logic [SAMPLE_W-1:0] ext [NUM_WSEL];
   logic [CNT_W-1:0]    n_bits;
   logic [CNT_W-1:0]    last_idx;
   logic                is_rj;

   assign is_rj = (fmt.frame == FRM_RJ);
   assign src   = is_rj ? sr_q : word_now;

   for (genvar g = 0; g < NUM_WSEL; g++) begin : g_ext
      localparam int WG = (g == 0) ? W_SHORT : (g == 1) ? W_MID : SAMPLE_W;
      if (WG == SAMPLE_W) begin : g_full
         assign ext[g] = src;
      end else begin : g_sext
         assign ext[g] = {{(SAMPLE_W - WG){src[WG-1]}}, src[WG-1:0]};
      end
   end

   always_comb begin
      case (fmt.wsel)
         WSEL_SHORT: begin
            n_bits   = CNT_W'(W_SHORT);
            cap_word = ext[0];
         end
         WSEL_MID: begin
            n_bits   = CNT_W'(W_MID);
            cap_word = ext[1];
         end
         default: begin
            n_bits   = CNT_W'(SAMPLE_W);
            cap_word = ext[2];
         end
      endcase
   end

   assign last_idx = n_bits - 1'b1 + ((fmt.frame == FRM_I2S) ? 1'b1 : 1'b0);

   always_comb begin
      if (is_rj) begin
         cap_stb  = slot_edge && synced;
         cap_left = prev_left;
      end else begin
         cap_stb  = synced && !slot_edge && (bit_idx == last_idx);
         cap_left = cur_left;
      end
   end
endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_stb,
   input  logic                cap_left,
   input  logic [SAMPLE_W-1:0] cap_word,
   output logic [SAMPLE_W-1:0] left_word,
   output logic [SAMPLE_W-1:0] right_word,
   output logic                pair_valid
);
   logic [SAMPLE_W-1:0] left_hold;
   logic                have_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold  <= '0;
         have_left  <= 1'b0;
         left_word  <= '0;
         right_word <= '0;
         pair_valid <= 1'b0;
      end else begin
         pair_valid <= 1'b0;
         if (cap_stb && cap_left) begin
            left_hold <= cap_word;
            have_left <= 1'b1;
         end else if (cap_stb && have_left) begin
            left_word  <= left_hold;
            right_word <= cap_word;
            pair_valid <= 1'b1;
            have_left  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/aud_frame_rx.sv
module aud_frame_rx
   import aud_rx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int W_SHORT  = 16,
   parameter int W_MID    = 20
) (
   input  logic                clk_bit,
   input  logic                rst_n,
   input  logic                wclk,
   input  logic                sdata,
   input  logic [2:0]          fmt_code,
   input  logic                lr_pol,
   output logic [SAMPLE_W-1:0] left_word,
   output logic [SAMPLE_W-1:0] right_word,
   output logic                pair_valid
);
   localparam int CNT_W = $clog2(SAMPLE_W + 2);

   if (W_SHORT < 2 || W_SHORT >= W_MID || W_MID >= SAMPLE_W) begin : g_bad_widths
      $error("aud_frame_rx: widths must satisfy 2 <= W_SHORT < W_MID < SAMPLE_W");
   end

   fmt_t                fmt;
   logic                slot_edge;
   logic [CNT_W-1:0]    bit_idx;
   logic                cur_left;
   logic                prev_left;
   logic                synced;
   logic [SAMPLE_W-1:0] sr_q;
   logic [SAMPLE_W-1:0] word_now;
   logic                cap_stb;
   logic                cap_left;
   logic [SAMPLE_W-1:0] cap_word;

   assign fmt = decode_fmt(fmt_code);

   aud_rx_slot #(.CNT_W(CNT_W)) slot_i (
      .clk       (clk_bit),
      .rst_n     (rst_n),
      .wclk      (wclk),
      .lr_pol    (lr_pol),
      .slot_edge (slot_edge),
      .bit_idx   (bit_idx),
      .cur_left  (cur_left),
      .prev_left (prev_left),
      .synced    (synced)
   );

   aud_rx_shift #(.W(SAMPLE_W)) shift_i (
      .clk      (clk_bit),
      .rst_n    (rst_n),
      .sdata    (sdata),
      .sr_q     (sr_q),
      .word_now (word_now)
   );

   aud_rx_capture #(
      .SAMPLE_W (SAMPLE_W),
      .W_SHORT  (W_SHORT),
      .W_MID    (W_MID),
      .CNT_W    (CNT_W)
   ) cap_i (
      .fmt       (fmt),
      .slot_edge (slot_edge),
      .bit_idx   (bit_idx),
      .synced    (synced),
      .cur_left  (cur_left),
      .prev_left (prev_left),
      .sr_q      (sr_q),
      .word_now  (word_now),
      .cap_stb   (cap_stb),
      .cap_left  (cap_left),
      .cap_word  (cap_word)
   );

   aud_rx_pair #(.SAMPLE_W(SAMPLE_W)) pair_i (
      .clk        (clk_bit),
      .rst_n      (rst_n),
      .cap_stb    (cap_stb),
      .cap_left   (cap_left),
      .cap_word   (cap_word),
      .left_word  (left_word),
      .right_word (right_word),
      .pair_valid (pair_valid)
   );
endmodule

// File: rtl/aud_frame_rx_chk.sv
module aud_frame_rx_chk #(
   parameter int SAMPLE_W = 24,
   parameter int W_SHORT  = 16,
   parameter int W_MID    = 20
) (
   input logic                clk_bit,
   input logic                rst_n,
   input logic                wclk,
   input logic                sdata,
   input logic [2:0]          fmt_code,
   input logic                lr_pol,
   input logic [SAMPLE_W-1:0] left_word,
   input logic [SAMPLE_W-1:0] right_word,
   input logic                pair_valid
);
   logic rj_mode;
   logic short_mode;
   assign rj_mode    = (fmt_code == 3'b000) || (fmt_code == 3'b001) || (fmt_code == 3'b010);
   assign short_mode = (fmt_code == 3'b000) || (fmt_code == 3'b100);

   // R9: reset keeps the strobe and outputs quiet
   a_r9_reset_quiet: assert property (@(posedge clk_bit)
      !rst_n |-> (!pair_valid && left_word == '0 && right_word == '0));

   // R8: strobe lasts a single cycle
   a_r8_single_pulse: assert property (@(posedge clk_bit) disable iff (!rst_n)
      pair_valid |=> !pair_valid);

   // R8: outputs hold between strobes
   a_r8_hold_outputs: assert property (@(posedge clk_bit) disable iff (!rst_n)
      !pair_valid |-> ($stable(left_word) && $stable(right_word)));

   // R7: short words carry the sign through the upper bits
   a_r7_sext_short: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (pair_valid && short_mode) |->
         ((left_word[SAMPLE_W-1:W_SHORT-1] == '0 || left_word[SAMPLE_W-1:W_SHORT-1] == '1) &&
          (right_word[SAMPLE_W-1:W_SHORT-1] == '0 || right_word[SAMPLE_W-1:W_SHORT-1] == '1)));

   // R3 / R6: right-justified pair follows a word-clock edge leaving the right slot
   a_r3_rj_edge_from_right: assert property (@(posedge clk_bit) disable iff (!rst_n)
      (pair_valid && rj_mode) |->
         (($past(wclk) != $past(wclk, 2)) && (($past(wclk, 2) ^ lr_pol) == 1'b0)));
endmodule

bind aud_frame_rx aud_frame_rx_chk #(
   .SAMPLE_W (SAMPLE_W),
   .W_SHORT  (W_SHORT),
   .W_MID    (W_MID)
) chk_i (.*);

// File: tb/aud_frame_rx_tb_top.sv
module aud_frame_rx_tb_top;
   localparam int CLK_HALF = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wclk = 1'b0;
   logic        sdata = 1'b0;
   logic [2:0]  fmt_code = 3'b000;
   logic        lr_pol = 1'b0;
   logic [23:0] left_word;
   logic [23:0] right_word;
   logic        pair_valid;

   int n_checks = 0;
   int n_errors = 0;
   int n_got;
   logic [23:0] got_l [8];
   logic [23:0] got_r [8];

   always #(CLK_HALF) clk = ~clk;

   aud_frame_rx dut_i (
      .clk_bit    (clk),
      .rst_n      (rst_n),
      .wclk       (wclk),
      .sdata      (sdata),
      .fmt_code   (fmt_code),
      .lr_pol     (lr_pol),
      .left_word  (left_word),
      .right_word (right_word),
      .pair_valid (pair_valid)
   );

   // Monitor: record every strobe, sampled away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         n_got = 0;
      end else if (pair_valid) begin
         if (n_got < 8) begin
            got_l[n_got] = left_word;
            got_r[n_got] = right_word;
         end
         n_got = n_got + 1;
      end
   end

   // {code, pol, left, right}
   localparam logic [51:0] VEC [8] = '{
      {3'b000, 1'b0, 24'h008123, 24'h007F0E},
      {3'b001, 1'b1, 24'h09ABCD, 24'h012345},
      {3'b010, 1'b0, 24'hA5C3E1, 24'h3C5A96},
      {3'b011, 1'b1, 24'h7E0081, 24'hF00F11},
      {3'b100, 1'b0, 24'h00FFFF, 24'h000001},
      {3'b101, 1'b1, 24'h800000, 24'h7FFFFF},
      {3'b110, 1'b0, 24'h080001, 24'h0FFFFE},
      {3'b111, 1'b1, 24'h0C0F0F, 24'h03A5A5}
   };

   // R2: width per code
   function automatic int code_width(input logic [2:0] c);
      case (c)
         3'b000, 3'b100:         return 16;
         3'b001, 3'b110, 3'b111: return 20;
         default:                return 24;
      endcase
   endfunction

   // R2: 0 = right-justified, 1 = left-justified, 2 = I2S
   function automatic int code_frame(input logic [2:0] c);
      case (c)
         3'b000, 3'b001, 3'b010: return 0;
         3'b011, 3'b111:         return 1;
         default:                return 2;
      endcase
   endfunction

   function automatic string frame_tag(input logic [2:0] c);
      case (code_frame(c))
         0:       return "R3";
         1:       return "R4";
         default: return "R5";
      endcase
   endfunction

   // R7: sign extension from bit n-1
   function automatic logic [23:0] sext(input logic [23:0] v, input int n);
      logic [23:0] r;
      r = v;
      for (int b = n; b < 24; b++) r[b] = v[n-1];
      return r;
   endfunction

   // R1 / R3 / R4 / R5: bit i of a slot of slen bits, MSB first
   function automatic logic slot_bit(input logic [2:0] c, input logic [23:0] v,
                                     input int i, input int slen);
      int n;
      int start;
      int pos;
      n = code_width(c);
      case (code_frame(c))
         0:       start = slen - n;
         1:       start = 0;
         default: start = 1;
      endcase
      pos = i - start;
      if (pos >= 0 && pos < n) return v[n-1-pos];
      return (((i * 7 + 3) % 5) < 2);
   endfunction

   task automatic check(input logic ok, input string what,
                        input logic [23:0] act, input logic [23:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic drive_bit(input logic w, input logic d);
      @(negedge clk);
      wclk  = w;
      sdata = d;
   endtask

   // R6: left level is ~pol, right level is pol
   task automatic send_slot(input logic [2:0] c, input logic pol, input logic is_left,
                            input logic [23:0] v, input int slen);
      for (int i = 0; i < slen; i++)
         drive_bit(is_left ? ~pol : pol, slot_bit(c, v, i, slen));
   endtask

   task automatic do_reset(input logic [2:0] c, input logic pol, input logic start_lvl);
      @(negedge clk);
      rst_n    = 1'b0;
      fmt_code = c;
      lr_pol   = pol;
      wclk     = start_lvl;
      sdata    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_case(input logic [2:0] c, input logic pol, input logic [23:0] lv,
                           input logic [23:0] rv, input int slen, input string name);
      int n;
      n = code_width(c);
      do_reset(c, pol, pol);
      send_slot(c, pol, 1'b0, 24'h5A5A5A, 5);          // partial right slot (R9)
      send_slot(c, pol, 1'b1, lv, slen);
      send_slot(c, pol, 1'b0, rv, slen);
      send_slot(c, pol, 1'b1, ~lv, slen);
      send_slot(c, pol, 1'b0, ~rv, slen);
      send_slot(c, pol, 1'b1, 24'h000000, slen);       // trailing slot
      repeat (6) drive_bit(~pol, 1'b0);
      check(n_got == 2, $sformatf("R8 %s pair count", name), 24'(n_got), 24'd2);
      check(got_l[0] === sext(lv, n), $sformatf("R1 R2 R6 R7 %s %s left 0", frame_tag(c), name),
            got_l[0], sext(lv, n));
      check(got_r[0] === sext(rv, n), $sformatf("R1 R2 R6 R7 %s %s right 0", frame_tag(c), name),
            got_r[0], sext(rv, n));
      check(got_l[1] === sext(~lv, n), $sformatf("R2 R7 %s %s left 1", frame_tag(c), name),
            got_l[1], sext(~lv, n));
      check(got_r[1] === sext(~rv, n), $sformatf("R2 R7 %s %s right 1", frame_tag(c), name),
            got_r[1], sext(~rv, n));
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : stim
      // R9: reset state
      repeat (2) @(negedge clk);
      check(pair_valid == 1'b0, "R9 strobe in reset", 24'(pair_valid), 24'd0);
      check(left_word == 24'd0 && right_word == 24'd0, "R9 words in reset", left_word | right_word, 24'd0);

      // Table of all eight codes, 32-bit slots
      for (int k = 0; k < 8; k++)
         run_case(VEC[k][51:49], VEC[k][48], VEC[k][47:24], VEC[k][23:0], 32,
                  $sformatf("vec%0d", k));

      // R3: 24-bit right-justified in a slot of exactly 24 bits
      run_case(3'b010, 1'b1, 24'hC00003, 24'h2468AC, 24, "rj24 tight");
      // R5: 24-bit I2S in a 25-bit slot
      run_case(3'b101, 1'b0, 24'h13579B, 24'hFEDCBA, 25, "i2s24 tight");

      // R8: outputs hold with no strobe during idle
      repeat (20) drive_bit(1'b1, 1'b1);
      check(n_got == 2, "R8 no strobe while idle", 24'(n_got), 24'd2);
      check(left_word == sext(~24'h13579B, 24) && right_word == sext(~24'hFEDCBA, 24),
            "R8 words held", left_word, sext(~24'h13579B, 24));

      // R10 / R9: start inside a left slot, then a lone right word
      do_reset(3'b011, 1'b0, 1'b1);
      send_slot(3'b011, 1'b0, 1'b1, 24'h777777, 10);   // partial left slot
      send_slot(3'b011, 1'b0, 1'b0, 24'h123456, 32);   // right with no left
      check(n_got == 0, "R10 lone right word gives no strobe", 24'(n_got), 24'd0);
      send_slot(3'b011, 1'b0, 1'b1, 24'h654321, 32);
      send_slot(3'b011, 1'b0, 1'b0, 24'h89ABCD, 32);
      repeat (4) drive_bit(1'b1, 1'b0);
      check(n_got == 1, "R10 one strobe after full frame", 24'(n_got), 24'd1);
      check(got_l[0] === 24'h654321, "R10 R4 left after resync", got_l[0], 24'h654321);
      check(got_r[0] === 24'h89ABCD, "R10 R4 right after resync", got_r[0], 24'h89ABCD);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule